// File: doc/BRIEF.md
# Descriptor-Chain DMA Channel Engine

This block is a single DMA channel that walks a linked list of buffer descriptors kept in its own small descriptor RAM. A host fills descriptors and control registers through a word-addressed register port. Writing a nonzero descriptor pointer to the head register starts the walk. For each descriptor the engine raises a transfer request carrying the buffer pointer, the buffer length and the packet-boundary flags. It waits for a done pulse, writes the mode word back and follows the next pointer. The data movement itself is left to whatever answers the request.

Each descriptor is written back with ownership cleared. End-of-queue is set when the chain ends there. Because of this, software can append to a running chain by patching the tail's next pointer. The engine re-reads that pointer at write-back time, so a late append is still followed. If the engine had already stopped, software sees end-of-queue in the old tail and writes the head register again. A completion register records the last finished descriptor and raises `irq`, which the host clears by writing the same pointer back. A soft-reset register clears all channel state over a fixed number of cycles.

The engine is a five-state machine:
- ST_IDLE: waits for enable and a nonzero head, then goes to ST_FETCH.
- ST_FETCH: reads the four descriptor words in one cycle. If ownership is set it goes to ST_REQ; if not, it flags an error and goes back to ST_IDLE.
- ST_REQ: holds the request until `xfer_ready`, then goes to ST_WAIT.
- ST_WAIT: waits for `xfer_done`, then goes to ST_WRBACK.
- ST_WRBACK: writes the mode word back, unless a host RAM write takes the port that cycle. It then loads the head from the freshly read next pointer and returns to ST_IDLE.

A soft reset forces ST_IDLE from any state.

Top module: `dchain_dma`

## Requirements
- R1: After reset, every register reads 0, `xfer_valid` is 0 and `irq` is 0.
- R2: Host addresses with the top address bit set map one-to-one onto descriptor RAM words. A descriptor pointer equals the host address of its first word. The word order is next pointer (+0), buffer pointer (+1), buffer length (+2), mode (+3). The registers sit at offsets CTRL=0 (bit 0 enable), HEAD=1, COMPL=2, SRST=3 (bit 0) and STAT=4 (bit 0 error, bit 1 busy).
- R3: Once HEAD is written nonzero with enable set, descriptors are requested in chain order. `xfer_addr` carries word +1 and `xfer_len` the low LEN_W bits of word +2. `xfer_sop` and `xfer_eop` carry mode bits 31 and 30. The request stays asserted and stable until `xfer_ready` and drops the cycle after.
- R4: On `xfer_done`, the mode word is written back with ownership (bit 29) cleared. Bit 28 (end-of-queue) is set exactly when the next pointer read at write-back is 0. Bits 31, 30 and 27..0 are kept.
- R5: HEAD follows the chain and reads 0 after the last descriptor.
- R6: COMPL reads the pointer of the last written-back descriptor and `irq` rises with it. A host write equal to COMPL clears `irq`; any other value has no effect.
- R7: A fetched descriptor without ownership causes no request, leaves its mode word unchanged, sets STAT bit 0 and sets HEAD to 0. A later HEAD write clears the error.
- R8: With CTRL bit 0 clear, no new descriptor is started and HEAD is kept. Setting the bit resumes from HEAD.
- R9: Writing 1 to SRST bit 0 makes it read 1 for RST_CYC cycles and then 0. It drops any request, clears CTRL, HEAD, COMPL, STAT and `irq`, and leaves the descriptor RAM intact.
- R10: A next pointer patched before write-back is followed without end-of-queue. After end-of-queue, a fresh HEAD write restarts the walk.
- R11: A HEAD write while the machine is not in ST_IDLE is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host word address (AW = log2(NDESC*4)+1) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational |
| xfer_valid | output | 1 | Buffer transfer request |
| xfer_ready | input | 1 | Request accepted |
| xfer_addr | output | 32 | Buffer pointer of the request |
| xfer_len | output | LEN_W | Buffer length of the request |
| xfer_sop | output | 1 | Descriptor starts a packet |
| xfer_eop | output | 1 | Descriptor ends a packet |
| xfer_done | input | 1 | Transfer finished pulse |
| irq | output | 1 | Unacknowledged completion pending |

## Verification
The bench builds the block with its defaults: NDESC=16, LEN_W=16 and RST_CYC=4. With sixteen descriptors, every scenario gets its own slots: a three-deep chain, an error mid-chain, a late append, a restart after end-of-queue, a held request under soft reset and a disabled start. No slot is reused, so a stray write-back shows up as a wrong mode word. A four-cycle reset window is long enough to read SRST as 1 and then see it return to 0.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_REQ,
        ST_WAIT,
        ST_WRBACK
    } eng_state_t;

    // mode word bit positions
    localparam int MODE_SOP = 31;
    localparam int MODE_EOP = 30;
    localparam int MODE_OWN = 29;
    localparam int MODE_EOQ = 28;

    // word offsets inside a descriptor
    localparam int W_NEXT = 0;
    localparam int W_BUF  = 1;
    localparam int W_LEN  = 2;
    localparam int W_MODE = 3;

    // register offsets
    localparam int REG_CTRL  = 0;
    localparam int REG_HEAD  = 1;
    localparam int REG_COMPL = 2;
    localparam int REG_SRST  = 3;
    localparam int REG_STAT  = 4;

    typedef struct packed {
        logic [31:0] nxt;
        logic [31:0] buf_ptr;
        logic [31:0] len;
        logic [31:0] mode;
    } desc_t;

endpackage

// File: rtl/dchain_ram.sv
module dchain_ram
    import dchain_pkg::*;
#(
    parameter int NDESC = 16,
    localparam int IDXW = $clog2(NDESC)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [IDXW-1:0] w_idx,
    input  logic [1:0]      w_sel,
    input  logic [31:0]     w_data,
    input  logic [IDXW-1:0] h_idx,
    input  logic [1:0]      h_sel,
    output logic [31:0]     h_data,
    input  logic [IDXW-1:0] e_idx,
    output desc_t           e_desc
);

    logic [31:0] mem [NDESC][4];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[w_idx][w_sel] <= w_data;
        end
    end

    assign h_data = mem[h_idx][h_sel];

    always_comb begin
        e_desc.nxt     = mem[e_idx][W_NEXT];
        e_desc.buf_ptr = mem[e_idx][W_BUF];
        e_desc.len     = mem[e_idx][W_LEN];
        e_desc.mode    = mem[e_idx][W_MODE];
    end

endmodule

// File: rtl/dchain_ctl.sv
module dchain_ctl #(
    parameter int RST_CYC = 4,
    localparam int CNT_W  = $clog2(RST_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic srst_we,
    input  logic wbit,
    output logic en,
    output logic srst_act
);

    logic [CNT_W-1:0] cnt_q;

    assign srst_act = (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en    <= 1'b0;
        end else if (srst_act) begin
            cnt_q <= cnt_q - 1'b1;
            en    <= 1'b0;
        end else begin
            if (srst_we && wbit) begin
                cnt_q <= CNT_W'(RST_CYC);
            end
            if (ctrl_we) begin
                en <= wbit;
            end
        end
    end

endmodule

// File: rtl/dchain_eng.sv
module dchain_eng
    import dchain_pkg::*;
#(
    parameter int NDESC = 16,
    parameter int LEN_W = 16,
    localparam int IDXW = $clog2(NDESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             en,
    input  logic             head_we,
    input  logic             cmpl_we,
    input  logic [31:0]      wdata,
    input  logic             host_ram_we,
    input  desc_t            cur_desc,
    input  logic             xfer_ready,
    input  logic             xfer_done,
    output logic [IDXW-1:0]  cur_idx,
    output logic             wb_we,
    output logic [31:0]      wb_word,
    output logic [31:0]      head_q,
    output logic [31:0]      cmpl_q,
    output logic             err_q,
    output logic             irq_q,
    output logic             busy,
    output logic             xfer_valid,
    output logic [31:0]      xfer_addr,
    output logic [LEN_W-1:0] xfer_len,
    output logic             xfer_sop,
    output logic             xfer_eop
);

    eng_state_t state_q, state_d;

    logic [31:0]      mode_q;
    logic [31:0]      buf_q;
    logic [LEN_W-1:0] len_q;
    logic             own_ok;
    logic             wb_ok;
    logic             unused_len_hi;

    assign unused_len_hi = ^cur_desc.len[31:LEN_W];
    assign cur_idx       = head_q[IDXW+1:2];
    assign own_ok        = cur_desc.mode[MODE_OWN];
    assign wb_ok         = (state_q == ST_WRBACK) && !host_ram_we;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (srst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (en && head_q != '0) state_d = ST_FETCH;
            ST_FETCH:  state_d = own_ok ? ST_REQ : ST_IDLE;
            ST_REQ:    if (xfer_ready) state_d = ST_WAIT;
            ST_WAIT:   if (xfer_done) state_d = ST_WRBACK;
            ST_WRBACK: if (wb_ok) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        xfer_valid = (state_q == ST_REQ);
        busy       = (state_q != ST_IDLE);
        wb_we      = wb_ok;
        wb_word    = mode_q;
        wb_word[MODE_OWN] = 1'b0;
        wb_word[MODE_EOQ] = (cur_desc.nxt == '0);
        xfer_addr  = buf_q;
        xfer_len   = len_q;
        xfer_sop   = mode_q[MODE_SOP];
        xfer_eop   = mode_q[MODE_EOP];
    end

    // channel datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            cmpl_q <= '0;
            err_q  <= 1'b0;
            irq_q  <= 1'b0;
            mode_q <= '0;
            buf_q  <= '0;
            len_q  <= '0;
        end else if (srst) begin
            head_q <= '0;
            cmpl_q <= '0;
            err_q  <= 1'b0;
            irq_q  <= 1'b0;
            mode_q <= '0;
            buf_q  <= '0;
            len_q  <= '0;
        end else begin
            if (head_we && state_q == ST_IDLE) begin
                head_q <= wdata;
                err_q  <= 1'b0;
            end
            if (cmpl_we && wdata == cmpl_q) begin
                irq_q <= 1'b0;
            end
            if (state_q == ST_FETCH) begin
                if (own_ok) begin
                    mode_q <= cur_desc.mode;
                    buf_q  <= cur_desc.buf_ptr;
                    len_q  <= cur_desc.len[LEN_W-1:0];
                end else begin
                    err_q  <= 1'b1;
                    head_q <= '0;
                end
            end
            if (wb_ok) begin
                head_q <= cur_desc.nxt;
                cmpl_q <= head_q;
                irq_q  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
    import dchain_pkg::*;
#(
    parameter int NDESC   = 16,
    parameter int LEN_W   = 16,
    parameter int RST_CYC = 4,
    localparam int IDXW   = $clog2(NDESC),
    localparam int AW     = $clog2(NDESC * 4) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [AW-1:0]    host_addr,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    output logic             xfer_valid,
    input  logic             xfer_ready,
    output logic [31:0]      xfer_addr,
    output logic [LEN_W-1:0] xfer_len,
    output logic             xfer_sop,
    output logic             xfer_eop,
    input  logic             xfer_done,
    output logic             irq
);

    localparam logic [AW-2:0] OFF_CTRL  = (AW-1)'(REG_CTRL);
    localparam logic [AW-2:0] OFF_HEAD  = (AW-1)'(REG_HEAD);
    localparam logic [AW-2:0] OFF_COMPL = (AW-1)'(REG_COMPL);
    localparam logic [AW-2:0] OFF_SRST  = (AW-1)'(REG_SRST);
    localparam logic [AW-2:0] OFF_STAT  = (AW-1)'(REG_STAT);

    logic            ram_sel;
    logic [AW-2:0]   off;
    logic            host_ram_we;
    logic            reg_we;
    logic            en;
    logic            srst_act;
    logic            eng_we;
    logic [31:0]     eng_word;
    logic [IDXW-1:0] eng_idx;
    logic [31:0]     head_q;
    logic [31:0]     cmpl_q;
    logic            err_q;
    logic            busy;
    logic            ram_we;
    logic [IDXW-1:0] ram_widx;
    logic [1:0]      ram_wsel;
    logic [31:0]     ram_wdata;
    logic [31:0]     ram_hdata;
    desc_t           cur_desc;

    assign ram_sel     = host_addr[AW-1];
    assign off         = host_addr[AW-2:0];
    assign host_ram_we = host_we && ram_sel;
    assign reg_we      = host_we && !ram_sel;

    // host has priority on the single RAM write port
    assign ram_we    = host_ram_we || eng_we;
    assign ram_widx  = host_ram_we ? host_addr[AW-2:2] : eng_idx;
    assign ram_wsel  = host_ram_we ? host_addr[1:0] : 2'(W_MODE);
    assign ram_wdata = host_ram_we ? host_wdata : eng_word;

    dchain_ram #(.NDESC(NDESC)) u_ram (
        .clk    (clk),
        .we     (ram_we),
        .w_idx  (ram_widx),
        .w_sel  (ram_wsel),
        .w_data (ram_wdata),
        .h_idx  (host_addr[AW-2:2]),
        .h_sel  (host_addr[1:0]),
        .h_data (ram_hdata),
        .e_idx  (eng_idx),
        .e_desc (cur_desc)
    );

    dchain_ctl #(.RST_CYC(RST_CYC)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (reg_we && off == OFF_CTRL),
        .srst_we  (reg_we && off == OFF_SRST),
        .wbit     (host_wdata[0]),
        .en       (en),
        .srst_act (srst_act)
    );

    dchain_eng #(.NDESC(NDESC), .LEN_W(LEN_W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst        (srst_act),
        .en          (en),
        .head_we     (reg_we && off == OFF_HEAD),
        .cmpl_we     (reg_we && off == OFF_COMPL),
        .wdata       (host_wdata),
        .host_ram_we (host_ram_we),
        .cur_desc    (cur_desc),
        .xfer_ready  (xfer_ready),
        .xfer_done   (xfer_done),
        .cur_idx     (eng_idx),
        .wb_we       (eng_we),
        .wb_word     (eng_word),
        .head_q      (head_q),
        .cmpl_q      (cmpl_q),
        .err_q       (err_q),
        .irq_q       (irq),
        .busy        (busy),
        .xfer_valid  (xfer_valid),
        .xfer_addr   (xfer_addr),
        .xfer_len    (xfer_len),
        .xfer_sop    (xfer_sop),
        .xfer_eop    (xfer_eop)
    );

    always_comb begin
        host_rdata = '0;
        if (ram_sel) begin
            host_rdata = ram_hdata;
        end else begin
            case (off)
                OFF_CTRL:  host_rdata = {31'b0, en};
                OFF_HEAD:  host_rdata = head_q;
                OFF_COMPL: host_rdata = cmpl_q;
                OFF_SRST:  host_rdata = {31'b0, srst_act};
                OFF_STAT:  host_rdata = {30'b0, busy, err_q};
                default:   host_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dchain_dma_chk.sv
module dchain_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        srst_act,
    input logic        en,
    input logic        err_q,
    input logic        irq,
    input logic        xfer_valid,
    input logic        xfer_ready,
    input logic [31:0] xfer_addr
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || srst_act)
        (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr))); // R3

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n || srst_act)
        (xfer_valid && xfer_ready) |=> !xfer_valid); // R3

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !xfer_valid); // R7

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n || srst_act)
        $rose(xfer_valid) |-> $past(en, 2)); // R8

    AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_act && $past(srst_act)) |-> (!xfer_valid && !irq)); // R9

endmodule

bind dchain_dma dchain_dma_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst_act   (srst_act),
    .en         (en),
    .err_q      (err_q),
    .irq        (irq),
    .xfer_valid (xfer_valid),
    .xfer_ready (xfer_ready),
    .xfer_addr  (xfer_addr)
);

// File: tb/dchain_dma_tb.sv
`timescale 1ns/1ps
module dchain_dma_tb;

    localparam int AW = 7;
    localparam logic [31:0] OWN = 32'h2000_0000;
    localparam logic [31:0] SOP = 32'h8000_0000;
    localparam logic [31:0] EOP = 32'h4000_0000;
    localparam logic [31:0] EOQ = 32'h1000_0000;
    localparam logic [AW-1:0] A_CTRL = 7'd0, A_HEAD = 7'd1, A_COMPL = 7'd2,
                              A_SRST = 7'd3, A_STAT = 7'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic xfer_valid, xfer_sop, xfer_eop, irq;
    logic xfer_ready = 1'b0;
    logic xfer_done = 1'b0;
    logic [31:0] xfer_addr;
    logic [15:0] xfer_len;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dchain_dma u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
        .xfer_len(xfer_len), .xfer_sop(xfer_sop), .xfer_eop(xfer_eop),
        .xfer_done(xfer_done), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic put_desc(input logic [AW-1:0] p, input logic [31:0] nxt,
                            input logic [31:0] bp, input logic [31:0] ln,
                            input logic [31:0] md);
        wr(p, nxt); wr(p + 7'd1, bp); wr(p + 7'd2, ln); wr(p + 7'd3, md);
    endtask

    task automatic wait_req(input string tag, input logic [31:0] bp,
                            input logic [15:0] ln, input logic [1:0] fl);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (xfer_valid) break;
        end
        chk({tag, " valid"}, {31'b0, xfer_valid}, 32'd1);
        chk({tag, " addr"}, xfer_addr, bp);
        chk({tag, " len"}, {16'b0, xfer_len}, {16'b0, ln});
        chk({tag, " flags"}, {30'b0, xfer_sop, xfer_eop}, {30'b0, fl});
    endtask

    task automatic give_ready();
        @(negedge clk); xfer_ready = 1'b1;
        @(negedge clk); xfer_ready = 1'b0;
    endtask

    task automatic give_done();
        repeat (2) @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic serve(input string tag, input logic [31:0] bp,
                         input logic [15:0] ln, input logic [1:0] fl);
        wait_req(tag, bp, ln, fl);
        give_ready();
        give_done();
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CTRL, d);  chk("R1 ctrl", d, 0);
        rd(A_HEAD, d);  chk("R1 head", d, 0);
        rd(A_COMPL, d); chk("R1 compl", d, 0);
        rd(A_SRST, d);  chk("R1 srst", d, 0);
        rd(A_STAT, d);  chk("R1 stat", d, 0);
        chk("R1 valid/irq", {30'b0, xfer_valid, irq}, 0);
    endtask

    task automatic t_ram();
        logic [31:0] d;
        wr(7'd101, 32'hA5A5_1234);
        rd(7'd101, d); chk("R2 ram rw", d, 32'hA5A5_1234);
    endtask

    task automatic t_chain();
        logic [31:0] d;
        put_desc(7'd64, 32'd68, 32'h1000, 32'd100, SOP | EOP | OWN | 32'd100);
        put_desc(7'd68, 32'd72, 32'h2000, 32'd200, OWN | EOQ | 32'd200);
        put_desc(7'd72, 32'd0,  32'h3000, 32'd300, EOP | OWN | 32'd300);
        wr(A_CTRL, 32'd1);
        wr(A_HEAD, 32'd64);
        serve("R3 d0", 32'h1000, 16'd100, 2'b11);
        serve("R3 d1", 32'h2000, 16'd200, 2'b00);
        serve("R3 d2", 32'h3000, 16'd300, 2'b01);
        settle();
        rd(A_HEAD, d);  chk("R5 head end", d, 0);
        rd(A_COMPL, d); chk("R6 compl", d, 32'd72);
        chk("R6 irq set", {31'b0, irq}, 32'd1);
        rd(7'd67, d); chk("R4 d0 mode", d, 32'hC000_0064);
        rd(7'd71, d); chk("R4 d1 mode", d, 32'h0000_00C8);
        rd(7'd75, d); chk("R4 d2 mode eoq", d, 32'h5000_012C);
        rd(A_STAT, d); chk("R7 no err", d, 0);
    endtask

    task automatic t_ack();
        wr(A_COMPL, 32'd68);
        @(negedge clk); chk("R6 wrong ack", {31'b0, irq}, 32'd1);
        wr(A_COMPL, 32'd72);
        @(negedge clk); chk("R6 ack clears", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_own();
        logic [31:0] d;
        int seen;
        put_desc(7'd84, 32'd0, 32'h5000, 32'd64, SOP | EOP | 32'd64);
        wr(A_HEAD, 32'd84);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (xfer_valid) seen++;
        end
        chk("R7 no request", seen, 0);
        rd(A_STAT, d); chk("R7 err set", d, 32'd1);
        rd(A_HEAD, d); chk("R7 head zero", d, 0);
        rd(7'd87, d); chk("R7 mode kept", d, 32'hC000_0040);
        put_desc(7'd88, 32'd92, 32'h6000, 32'd16, SOP | OWN | 32'd16);
        put_desc(7'd92, 32'd0,  32'h7000, 32'd32, EOP | 32'd32);
        wr(A_HEAD, 32'd88);
        rd(A_STAT, d); chk("R7 err cleared by head", d[0], 0);
        serve("R7 d6", 32'h6000, 16'd16, 2'b10);
        settle();
        rd(A_STAT, d);  chk("R7 err mid chain", d, 32'd1);
        rd(A_COMPL, d); chk("R7 compl d6", d, 32'd88);
        rd(7'd95, d);   chk("R7 d7 mode kept", d, 32'h4000_0020);
        rd(A_HEAD, d);  chk("R7 head zero 2", d, 0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        int seen;
        wr(A_CTRL, 32'd0);
        put_desc(7'd96, 32'd0, 32'h8000, 32'd64, OWN | 32'd64);
        wr(A_HEAD, 32'd96);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (xfer_valid) seen++;
        end
        chk("R8 held off", seen, 0);
        rd(A_HEAD, d); chk("R8 head kept", d, 32'd96);
        wr(A_CTRL, 32'd1);
        serve("R8 resume", 32'h8000, 16'd64, 2'b00);
        settle();
        rd(A_HEAD, d); chk("R8 head end", d, 0);
    endtask

    task automatic t_busy_head();
        logic [31:0] d;
        put_desc(7'd100, 32'd0, 32'h9000, 32'd8, OWN | 32'd8);
        wr(A_HEAD, 32'd100);
        wait_req("R11 d9", 32'h9000, 16'd8, 2'b00);
        wr(A_HEAD, 32'd104);
        rd(A_HEAD, d); chk("R11 head write ignored", d, 32'd100);
        rd(A_STAT, d); chk("R11 busy", d, 32'd2);
        give_ready();
        give_done();
        settle();
        rd(A_HEAD, d); chk("R11 head end", d, 0);
    endtask

    task automatic t_append();
        logic [31:0] d;
        put_desc(7'd104, 32'd0, 32'hA000, 32'd16, OWN | 32'd16);
        put_desc(7'd108, 32'd0, 32'hB000, 32'd24, OWN | 32'd24);
        wr(A_HEAD, 32'd104);
        wait_req("R10 d10", 32'hA000, 16'd16, 2'b00);
        give_ready();
        wr(7'd104, 32'd108);
        give_done();
        serve("R10 late append", 32'hB000, 16'd24, 2'b00);
        settle();
        rd(7'd107, d); chk("R10 no eoq", d, 32'h0000_0010);
        rd(7'd111, d); chk("R10 eoq tail", d, 32'h1000_0018);
        put_desc(7'd112, 32'd0, 32'hC000, 32'd32, OWN | 32'd32);
        put_desc(7'd116, 32'd0, 32'hD000, 32'd40, OWN | 32'd40);
        wr(A_HEAD, 32'd112);
        serve("R10 d12", 32'hC000, 16'd32, 2'b00);
        settle();
        rd(7'd115, d); chk("R10 stopped eoq", d, 32'h1000_0020);
        rd(A_HEAD, d); chk("R10 stopped head", d, 0);
        wr(7'd112, 32'd116);
        wr(A_HEAD, 32'd116);
        serve("R10 restart", 32'hD000, 16'd40, 2'b00);
        settle();
        rd(7'd119, d);  chk("R10 d13 mode", d, 32'h1000_0028);
        rd(A_COMPL, d); chk("R10 compl", d, 32'd116);
    endtask

    task automatic t_srst();
        logic [31:0] d;
        put_desc(7'd120, 32'd0, 32'hE000, 32'd48, OWN | 32'd48);
        wr(A_HEAD, 32'd120);
        wait_req("R9 d14", 32'hE000, 16'd48, 2'b00);
        wr(A_SRST, 32'd1);
        rd(A_SRST, d); chk("R9 srst busy", d, 32'd1);
        chk("R9 request dropped", {31'b0, xfer_valid}, 0);
        repeat (6) @(negedge clk);
        rd(A_SRST, d);  chk("R9 srst done", d, 0);
        rd(A_HEAD, d);  chk("R9 head cleared", d, 0);
        rd(A_CTRL, d);  chk("R9 ctrl cleared", d, 0);
        rd(A_COMPL, d); chk("R9 compl cleared", d, 0);
        rd(A_STAT, d);  chk("R9 stat cleared", d, 0);
        chk("R9 irq cleared", {31'b0, irq}, 0);
        rd(7'd121, d);  chk("R9 ram kept", d, 32'hE000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ram();
        t_chain();
        t_ack();
        t_own();
        t_enable();
        t_busy_head();
        t_append();
        t_srst();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1-scope run hung: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule